// File: doc/BRIEF.md
# Parallel Scrambler and NRZI Channel Encoder

This block applies serial digital video channel coding to parallel words before they reach a serializer. Each word is treated as a run of serial bits sent least significant bit first. Every bit goes through a self-synchronizing scrambler built on the polynomial x^9 + x^4 + 1. The scrambled bit then goes through a differential (NRZI, x + 1) encoder. Both stages are unrolled across the word, so one full word is coded on each clock.

The word width is set at build time to 10 or 20 bits. The output word has the same width and bit alignment as the input word. A valid qualifier marks the clocks that carry a word. On other clocks the coding state is frozen and the last output word is held. The coded word appears one clock after its input word. The 9-bit scrambler history and the 1-bit NRZI history carry from the last bit of one word to the first bit of the next.

Top module: `sdi_chan_enc`

## Requirements
- R1: While rst_ni is low, data_o is all zero and valid_o is 0. The scrambler and NRZI histories clear to zero, so the first word after reset is coded as though all earlier bits were 0.
- R2: valid_o equals valid_i delayed by one clock. The coded form of a word presented with valid_i high appears on data_o on the next clock.
- R3: When valid_i is low, data_o keeps its previous value and no coding state advances. The coded stream of the valid words is therefore the same whether or not idle clocks lie between them.
- R4: For serial bit index n, the scrambled bit is s[n] = d[n] XOR s[n-4] XOR s[n-9].
- R5: The output bit is y[n] = s[n] XOR y[n-1].
- R6: Bit i of a word has serial index k*W + i for the k-th valid word. Bit 0 is coded first, and both histories continue across word boundaries. After reset, a first word holding only bit 0 set codes in a 10-bit build to 10'h10F.
- R7: The parameter W accepts only 10 and 20. Both widths follow R4 to R6 with their own word size.
- R8: An NRZI decoder followed by a self-synchronizing descrambler recovers the input words from data_o. This holds from any starting decoder state, once the first coded word (at least 10 bits) has passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A word is presented on data_i this clock |
| data_i | input | W | Parallel input word, bit 0 sent first |
| valid_o | output | 1 | data_o holds a newly coded word |
| data_o | output | W | Scrambled, NRZI-coded word |

## Verification
The assertions assume that reset is applied before the first word and that valid_i and data_i are steady around the rising clock edge. The recovery assertion also assumes the decoder's single-word warm-up is enough, which is true for W of 10 or more. The stimulus changes inputs only on falling edges and resets before each scenario. Idle clocks are inserted only by deasserting valid_i, never by leaving data_i undriven, so every valid word is fully defined.

// File: rtl/sdi_chan_pkg.sv
package sdi_chan_pkg;
  localparam int SCR_LEN = 9;
  localparam int SCR_TAP = 4;

  function automatic bit legal_width(int w);
    return (w == 10) || (w == 20);
  endfunction
endpackage

// File: rtl/scr_unroll.sv
module scr_unroll
  import sdi_chan_pkg::*;
#(
  parameter int W = 20
) (
  input  logic [W-1:0]       data_i,
  input  logic [SCR_LEN-1:0] hist_i,  // [SCR_LEN-1] = newest scrambled bit
  output logic [W-1:0]       scr_o,
  output logic [SCR_LEN-1:0] hist_o
);
  localparam int EXT = W + SCR_LEN;
  localparam int OFS = SCR_LEN - SCR_TAP;

  logic [EXT-1:0] ext;

  assign ext[SCR_LEN-1:0] = hist_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign ext[SCR_LEN+i] = data_i[i] ^ ext[OFS+i] ^ ext[i];
  end

  assign scr_o  = ext[EXT-1:SCR_LEN];
  assign hist_o = ext[EXT-1:W];
endmodule

// File: rtl/nrzi_unroll.sv
module nrzi_unroll #(
  parameter int W = 20
) (
  input  logic [W-1:0] bits_i,
  input  logic         prev_i,
  output logic [W-1:0] bits_o,
  output logic         last_o
);
  logic [W:0] chain;

  assign chain[0] = prev_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign chain[i+1] = chain[i] ^ bits_i[i];
  end

  assign bits_o = chain[W:1];
  assign last_o = chain[W];
endmodule

// File: rtl/sdi_chan_enc.sv
module sdi_chan_enc
  import sdi_chan_pkg::*;
#(
  parameter int W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  if (!legal_width(W)) begin : g_bad_width
    $error("sdi_chan_enc: W must be 10 or 20");
  end

  logic [SCR_LEN-1:0] hist_q, hist_d;
  logic               nrzi_q, nrzi_d;
  logic [W-1:0]       scr_w, enc_w;

  scr_unroll #(.W(W)) u_scr (
    .data_i (data_i),
    .hist_i (hist_q),
    .scr_o  (scr_w),
    .hist_o (hist_d)
  );

  nrzi_unroll #(.W(W)) u_nrzi (
    .bits_i (scr_w),
    .prev_i (nrzi_q),
    .bits_o (enc_w),
    .last_o (nrzi_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q  <= '0;
      nrzi_q  <= 1'b0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        hist_q <= hist_d;
        nrzi_q <= nrzi_d;
        data_o <= enc_w;
      end
    end
  end
endmodule

// File: rtl/sdi_chan_enc_chk.sv
module sdi_chan_enc_chk #(
  parameter int W = 20
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [W-1:0] data_i,
  input logic         valid_o,
  input logic [W-1:0] data_o
);
  // independent decoder: starts from all-ones to mimic an unsynced receiver
  logic [W-1:0] exp_q;
  logic [8:0]   dh_q;     // [8] = newest NRZI-decoded bit
  logic         dy_q;
  logic         seen_q;
  logic [W+8:0] xe;
  logic [W:0]   ye;
  logic [W-1:0] rec;

  always_comb begin
    ye[0]   = dy_q;
    xe[8:0] = dh_q;
    for (int i = 0; i < W; i++) begin
      ye[i+1] = data_o[i];
      xe[9+i] = data_o[i] ^ ye[i];
      rec[i]  = xe[9+i] ^ xe[5+i] ^ xe[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q  <= '0;
      dh_q   <= '1;
      dy_q   <= 1'b1;
      seen_q <= 1'b0;
    end else begin
      if (valid_i) exp_q <= data_i;
      if (valid_o) begin
        dh_q   <= xe[W+8:W];
        dy_q   <= ye[W];
        seen_q <= 1'b1;
      end
    end
  end

  assert_valid_lat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_idle_lat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));

  assert_recover_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && seen_q) |-> (rec == exp_q));
endmodule

bind sdi_chan_enc sdi_chan_enc_chk #(.W(W)) u_chk (.*);

// File: tb/sim_sdi_chan_enc.sv
module sim_sdi_chan_enc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        v = 1'b0;
  logic [19:0] d = '0;
  logic        v0o, v1o;
  logic [19:0] q0;
  logic [9:0]  q1;

  sdi_chan_enc #(.W(20)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(v), .data_i(d),
    .valid_o(v0o), .data_o(q0));

  sdi_chan_enc #(.W(10)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(v), .data_i(d[9:0]),
    .valid_o(v1o), .data_o(q1));

  int n_cmp = 0;
  int n_bad = 0;

  logic [8:0]  ms0, ms1;   // model scrambler history, [0] = newest
  logic        my0, my1;
  logic [19:0] last0;
  logic [9:0]  last1;
  logic [8:0]  dh;         // bench decoder on u0
  logic        dy;
  int          dseen;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic model(input int w, input logic [19:0] din,
                       inout logic [8:0] s, inout logic y, output logic [19:0] o);
    o = '0;
    for (int i = 0; i < w; i++) begin
      logic b;
      b = din[i] ^ s[3] ^ s[8];
      s = {s[7:0], b};
      y = y ^ b;
      o[i] = y;
    end
  endtask

  task automatic decode_chk(input logic [19:0] code, input logic [19:0] din);
    logic [19:0] r;
    r = '0;
    for (int i = 0; i < 20; i++) begin
      logic x;
      x = code[i] ^ dy;
      dy = code[i];
      r[i] = x ^ dh[3] ^ dh[8];
      dh = {dh[7:0], x};
    end
    if (dseen > 0) chk("R8 recovered data", r, din);
    dseen++;
  endtask

  // entered just after a falling edge
  task automatic step(input logic vin, input logic [19:0] din);
    logic [19:0] e0, e1;
    v = vin;
    d = din;
    if (vin) begin
      model(20, din, ms0, my0, e0);
      model(10, din, ms1, my1, e1);
    end else begin
      e0 = last0;
      e1 = {10'd0, last1};
    end
    @(posedge clk);
    #1;
    chk("R2 valid_o w20", {31'd0, v0o}, {31'd0, vin});
    chk("R2 valid_o w10", {31'd0, v1o}, {31'd0, vin});
    if (vin) begin
      chk("R4 R5 R6 R7 data w20", {12'd0, q0}, {12'd0, e0});
      chk("R4 R5 R6 R7 data w10", {22'd0, q1}, {12'd0, e1});
      decode_chk(q0, din);
    end else begin
      chk("R3 hold w20", {12'd0, q0}, {12'd0, e0});
      chk("R3 hold w10", {22'd0, q1}, {12'd0, e1});
    end
    last0 = e0;
    last1 = e1[9:0];
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    v = 1'b0;
    d = '0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 data_o w20", {12'd0, q0}, 32'd0);
    chk("R1 data_o w10", {22'd0, q1}, 32'd0);
    chk("R1 valid_o", {30'd0, v0o, v1o}, 32'd0);
    ms0 = '0; ms1 = '0; my0 = 1'b0; my1 = 1'b0;
    last0 = '0; last1 = '0;
    dh = '1; dy = 1'b1; dseen = 0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_zero_run;
    t_reset();
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 20'd0);
      chk("R1 R4 zero state keeps zero", {12'd0, q0}, 32'd0);
    end
  endtask

  task automatic t_impulse;
    t_reset();
    step(1'b1, 20'd1);
    chk("R6 impulse w10", {22'd0, q1}, 32'h10F);
    for (int k = 0; k < 3; k++) step(1'b1, 20'd0);
  endtask

  task automatic t_gaps;
    t_reset();
    for (int k = 0; k < 12; k++) begin
      step(1'b1, 20'hA5C3F ^ (20'(k) << 3));
      for (int g = 0; g < (k % 3); g++) step(1'b0, 20'hFFFFF);
    end
  endtask

  task automatic t_ones;
    t_reset();
    for (int k = 0; k < 8; k++) step(1'b1, 20'hFFFFF);
    for (int k = 0; k < 8; k++) step(1'b1, 20'h55555);
  endtask

  task automatic t_random;
    t_reset();
    for (int k = 0; k < 300; k++) begin
      logic [31:0] rv;
      rv = $urandom;
      step(rv[31:28] != 4'h0, rv[19:0]);
    end
  endtask

  task automatic t_midreset;
    t_reset();
    for (int k = 0; k < 5; k++) step(1'b1, 20'h3C0F1 + 20'(k));
    t_reset();
    step(1'b1, 20'd1);
    chk("R1 R6 state cleared by reset", {22'd0, q1}, 32'h10F);
  endtask

  initial begin
    @(negedge clk);
    t_zero_run();
    t_impulse();
    t_gaps();
    t_ones();
    t_random();
    t_midreset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule